// File: doc/BRIEF.md
# Hint-Aware Set-Associative Tag and Replacement Controller

This block is the tag and replacement controller of a single-level data cache. The default has four ways, 64 sets and a 32-bit address, split into a 4-bit byte offset, a 6-bit set index and a 22-bit tag. Each set keeps a binary pseudo-LRU tree. The cache line is 16 bytes, so one line carries a 128-bit load word. The block accepts one request per cycle. It answers a hit in the next cycle. On a miss it raises a fill request toward memory and waits for a single-beat acknowledge. It then installs the tag in the chosen victim way and reports the result.

Each request carries two qualifiers. The low-reuse flag leaves the touched way as the next eviction candidate of its set, instead of making it the most recent. A stream of low-reuse data therefore cycles through one way and does not flush the rest of the set. The uncached flag makes the access bypass allocation entirely. The data array, refill beat sequencing and coherence are handled elsewhere.

Top module: `hint_cache_ctrl`

## Requirements
- R1: After reset or an invalidate-all, every access misses. On a miss the lowest-numbered invalid way of the set is the victim, so the first four fills of an empty set go to ways 0, 1, 2 and 3 in that order.
- R2: A request accepted while the line is resident produces `resp_valid_o` with `resp_hit_o`=1 and `resp_way_o` equal to the holding way in the cycle after acceptance, and raises no fill request.
- R3: A miss raises `fill_req_o` from the cycle after acceptance, with `fill_addr_o` equal to the request address with its 4 offset bits cleared. Address and request stay steady until `fill_ack_i` is sampled high, and `req_ready_o` is low throughout.
- R4: The cycle after `fill_ack_i` is sampled, a single response appears with `resp_hit_o`=0 and `resp_way_o` equal to the victim way. For a cacheable request, a later access to the same line hits in that way.
- R5: When a set is full, the victim follows the tree. Each node bit selects the less recently used half, with 0 meaning the lower-numbered half. A normal hit or fill points every node on its path away from the touched way. Filling ways 0 to 3 in order therefore makes way 0 the next victim.
- R6: A low-reuse hit or fill points every node on its path toward the touched way, so that way becomes the next victim of its set.
- R7: Successive low-reuse misses to one full set refill the same way, and the lines in the other three ways remain resident.
- R8: An uncached request installs no tag on a miss. Hit or miss, it leaves valid bits and tree state unchanged, and it reports hit and way like any other request.
- R9: `inval_all_i` held high for one idle cycle clears every valid bit and every tree bit. `req_ready_o` is low during that cycle.
- R10: While no fill is outstanding and no invalidate is requested, `req_ready_o` is high and one request is accepted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inval_all_i | input | 1 | Invalidate every line and clear the replacement state |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_addr_i | input | 32 | Byte address of the request |
| req_hint_i | input | 1 | Low-reuse qualifier: leave the line as next victim |
| req_nc_i | input | 1 | Uncached qualifier: never allocate, never update state |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_hit_o | output | 1 | Response was a hit |
| resp_way_o | output | 2 | Hit way, or victim way on a miss |
| fill_req_o | output | 1 | Line fetch from memory outstanding |
| fill_addr_o | output | 32 | Line-aligned fetch address |
| fill_ack_i | input | 1 | Single-beat fill completion from memory |

## Verification
The hardest state to reach is a full set whose tree mixes low-reuse and normal touches. In that state the victim differs from true LRU, and an uncached hit must visibly fail to move it. Directed sequences fill one set in order and apply a low-reuse hit. They then apply an uncached hit to a way that a normal touch would have protected, and read the effect back through the victim way of the next miss. Random traffic confined to two sets and six tags, with variable fill latency and rare invalidates, keeps sets full and eviction frequent. A bench-side tree model predicts every hit and victim.

// File: rtl/hc_pkg.sv
package hc_pkg;
    typedef enum logic {
        HC_IDLE = 1'b0,
        HC_FILL = 1'b1
    } hc_state_e;
endpackage

// File: rtl/hc_lookup.sv
module hc_lookup #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags_i,
    input  logic [WAYS-1:0]            set_valid_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           hit_way_o,
    output logic                       free_o,
    output logic [WAY_W-1:0]           free_way_o
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = set_valid_i[w] && (set_tags_i[w] == tag_i);
    end

    always_comb begin
        hit_o      = 1'b0;
        hit_way_o  = '0;
        free_o     = 1'b0;
        free_way_o = '0;
        // scan downward so the lowest index is the one kept
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_o     = 1'b1;
                hit_way_o = WAY_W'(w);
            end
            if (!set_valid_i[w]) begin
                free_o     = 1'b1;
                free_way_o = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/hc_plru.sv
module hc_plru #(
    parameter int WAYS = 4,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int TREE_W = WAYS - 1
) (
    input  logic [TREE_W-1:0] tree_i,
    input  logic [WAY_W-1:0]  touch_way_i,
    input  logic              touch_hint_i,
    output logic [WAY_W-1:0]  victim_o,
    output logic [TREE_W-1:0] tree_o
);
    // node n has children 2n+1 (lower half) and 2n+2 (upper half)
    always_comb begin
        int node;
        node = 0;
        victim_o = '0;
        for (int l = 0; l < WAY_W; l++) begin
            victim_o[WAY_W-1-l] = tree_i[node];
            node = 2 * node + 1 + int'(tree_i[node]);
        end
    end

    always_comb begin
        int  node;
        logic dir;
        node   = 0;
        tree_o = tree_i;
        for (int l = 0; l < WAY_W; l++) begin
            dir = touch_way_i[WAY_W-1-l];
            tree_o[node] = touch_hint_i ? dir : ~dir;
            node = 2 * node + 1 + int'(dir);
        end
    end
endmodule

// File: rtl/hint_cache_ctrl.sv
module hint_cache_ctrl #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 4,
    parameter int IDX_W  = 6,
    parameter int WAYS   = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              inval_all_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              req_hint_i,
    input  logic              req_nc_i,
    output logic              resp_valid_o,
    output logic              resp_hit_o,
    output logic [$clog2(WAYS)-1:0] resp_way_o,
    output logic              fill_req_o,
    output logic [ADDR_W-1:0] fill_addr_o,
    input  logic              fill_ack_i
);
    import hc_pkg::*;

    localparam int SETS   = 1 << IDX_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TREE_W = WAYS - 1;

    typedef struct packed {
        hc_state_e                                state;
        logic [ADDR_W-1:0]                        addr;
        logic                                     hint;
        logic                                     nc;
        logic [WAY_W-1:0]                         way;
        logic                                     rsp_v;
        logic                                     rsp_hit;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]     tags;
        logic [SETS-1:0][WAYS-1:0]                valid;
        logic [SETS-1:0][TREE_W-1:0]              tree;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  req_tag;
    logic              lk_hit, lk_free;
    logic [WAY_W-1:0]  lk_hit_way, lk_free_way;
    logic [WAY_W-1:0]  pl_victim, pl_touch_way;
    logic              pl_touch_hint;
    logic [TREE_W-1:0] pl_tree_upd;
    logic              accept;

    assign req_tag = req_addr_i[ADDR_W-1 -: TAG_W];
    assign cur_idx = (r_q.state == HC_FILL) ? r_q.addr[OFFS_W +: IDX_W]
                                            : req_addr_i[OFFS_W +: IDX_W];

    hc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) i_lookup (
        .set_tags_i  (r_q.tags[cur_idx]),
        .set_valid_i (r_q.valid[cur_idx]),
        .tag_i       (req_tag),
        .hit_o       (lk_hit),
        .hit_way_o   (lk_hit_way),
        .free_o      (lk_free),
        .free_way_o  (lk_free_way)
    );

    assign pl_touch_way  = (r_q.state == HC_FILL) ? r_q.way  : lk_hit_way;
    assign pl_touch_hint = (r_q.state == HC_FILL) ? r_q.hint : req_hint_i;

    hc_plru #(.WAYS(WAYS)) i_plru (
        .tree_i       (r_q.tree[cur_idx]),
        .touch_way_i  (pl_touch_way),
        .touch_hint_i (pl_touch_hint),
        .victim_o     (pl_victim),
        .tree_o       (pl_tree_upd)
    );

    assign accept = (r_q.state == HC_IDLE) && req_valid_i && !inval_all_i;

    always_comb begin
        r_d       = r_q;
        r_d.rsp_v = 1'b0;

        if (accept) begin
            r_d.addr = req_addr_i;
            r_d.hint = req_hint_i;
            r_d.nc   = req_nc_i;
            if (lk_hit) begin
                r_d.rsp_v   = 1'b1;
                r_d.rsp_hit = 1'b1;
                r_d.way     = lk_hit_way;
                if (!req_nc_i) begin
                    r_d.tree[cur_idx] = pl_tree_upd;
                end
            end else begin
                r_d.state = HC_FILL;
                r_d.way   = lk_free ? lk_free_way : pl_victim;
            end
        end

        if ((r_q.state == HC_FILL) && fill_ack_i) begin
            r_d.state   = HC_IDLE;
            r_d.rsp_v   = 1'b1;
            r_d.rsp_hit = 1'b0;
            if (!r_q.nc) begin
                r_d.tags[cur_idx][r_q.way]  = r_q.addr[ADDR_W-1 -: TAG_W];
                r_d.valid[cur_idx][r_q.way] = 1'b1;
                r_d.tree[cur_idx]           = pl_tree_upd;
            end
        end

        if (inval_all_i) begin
            r_d.valid = '0;
            r_d.tree  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.state <= HC_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready_o  = (r_q.state == HC_IDLE) && !inval_all_i;
    assign resp_valid_o = r_q.rsp_v;
    assign resp_hit_o   = r_q.rsp_hit;
    assign resp_way_o   = r_q.way;
    assign fill_req_o   = (r_q.state == HC_FILL);
    assign fill_addr_o  = {r_q.addr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
endmodule

// File: rtl/hc_checker.sv
module hc_checker #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              inval_all_i,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              resp_valid_o,
    input logic              resp_hit_o,
    input logic              fill_req_o,
    input logic [ADDR_W-1:0] fill_addr_o,
    input logic              fill_ack_i
);
    // R3: no new request while a fill is outstanding
    a_r3_ready_low_in_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_req_o |-> !req_ready_o);

    // R3: fill request and address held until acknowledged
    a_r3_fill_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_req_o && !fill_ack_i) |=> (fill_req_o && $stable(fill_addr_o)));

    // R4: acknowledge yields a miss response and ends the fill
    a_r4_ack_gives_miss_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_req_o && fill_ack_i) |=> (resp_valid_o && !resp_hit_o && !fill_req_o));

    // R10: every accepted request is answered or turns into a fill
    a_r10_accept_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o) |=> ((resp_valid_o && resp_hit_o) || fill_req_o));

    // R2: a hit response is always the answer to the previous acceptance
    a_r2_hit_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resp_valid_o && resp_hit_o) |-> $past(req_valid_i && req_ready_o));

    // R9: invalidate blocks acceptance
    a_r9_inval_blocks_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inval_all_i |-> !req_ready_o);

    // R3: fetch address is line aligned
    a_r3_fill_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_req_o |-> (fill_addr_o[OFFS_W-1:0] == '0));
endmodule

bind hint_cache_ctrl hc_checker #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) i_hc_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .inval_all_i  (inval_all_i),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .resp_valid_o (resp_valid_o),
    .resp_hit_o   (resp_hit_o),
    .fill_req_o   (fill_req_o),
    .fill_addr_o  (fill_addr_o),
    .fill_ack_i   (fill_ack_i)
);

// File: tb/test_hint_cache_ctrl.sv
module test_hint_cache_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inval = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_hint = 1'b0;
    logic        req_nc = 1'b0;
    logic        resp_valid, resp_hit;
    logic [1:0]  resp_way;
    logic        fill_req;
    logic [31:0] fill_addr;
    logic        fill_ack = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hint_cache_ctrl i_hint_cache_ctrl (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .inval_all_i  (inval),
        .req_valid_i  (req_valid),
        .req_ready_o  (req_ready),
        .req_addr_i   (req_addr),
        .req_hint_i   (req_hint),
        .req_nc_i     (req_nc),
        .resp_valid_o (resp_valid),
        .resp_hit_o   (resp_hit),
        .resp_way_o   (resp_way),
        .fill_req_o   (fill_req),
        .fill_addr_o  (fill_addr),
        .fill_ack_i   (fill_ack)
    );

    // reference state
    logic [21:0] m_tag [64][4];
    bit          m_val [64][4];
    bit   [2:0]  m_tree [64];
    bit          last_hit;
    int          last_way;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void m_clear();
        for (int s = 0; s < 64; s++) begin
            m_tree[s] = '0;
            for (int w = 0; w < 4; w++) m_val[s][w] = 1'b0;
        end
    endfunction

    function automatic int m_victim(int s);
        for (int w = 0; w < 4; w++) if (!m_val[s][w]) return w;
        if (!m_tree[s][0]) return m_tree[s][1] ? 1 : 0;
        return m_tree[s][2] ? 3 : 2;
    endfunction

    function automatic void m_touch(int s, int w, bit h);
        bit hi, lo;
        hi = w[1];
        lo = w[0];
        m_tree[s][0] = h ? hi : !hi;
        if (!hi) m_tree[s][1] = h ? lo : !lo;
        else     m_tree[s][2] = h ? lo : !lo;
    endfunction

    function automatic logic [31:0] mk_addr(int s, int t, int off);
        return {22'(t), 6'(s), 4'(off)};
    endfunction

    task automatic do_access(input logic [31:0] a, input bit h, input bit nc, input int lat);
        int s, hw, v;
        bit eh;
        logic [21:0] t;
        s  = int'(a[9:4]);
        t  = a[31:10];
        eh = 1'b0;
        hw = 0;
        for (int w = 3; w >= 0; w--)
            if (m_val[s][w] && m_tag[s][w] == t) begin eh = 1'b1; hw = w; end
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready when idle", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_hint = h; req_nc = nc;
        @(negedge clk);
        req_valid = 1'b0;
        if (eh) begin
            chk(resp_valid && resp_hit, "R2", "hit response", {resp_valid, resp_hit}, 3);
            chk(resp_way == 2'(hw), "R2", "hit way", resp_way, hw);
            chk(!fill_req, "R2", "no fill on hit", fill_req, 0);
            if (!nc) m_touch(s, hw, h);
            last_hit = 1'b1;
            last_way = int'(resp_way);
        end else begin
            v = m_victim(s);
            chk(fill_req && !resp_valid, "R3", "fill raised", {fill_req, resp_valid}, 2);
            chk(fill_addr == {a[31:4], 4'h0}, "R3", "fill address", fill_addr, {a[31:4], 4'h0});
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                chk(fill_req && !req_ready && fill_addr == {a[31:4], 4'h0}, "R3",
                    "fill held", fill_addr, {a[31:4], 4'h0});
            end
            fill_ack = 1'b1;
            @(negedge clk);
            fill_ack = 1'b0;
            chk(resp_valid && !resp_hit && !fill_req, "R4", "miss response",
                {resp_valid, resp_hit, fill_req}, 4);
            chk(resp_way == 2'(v), "R4", "victim way", resp_way, v);
            if (!nc) begin
                m_tag[s][v] = t;
                m_val[s][v] = 1'b1;
                m_touch(s, v, h);
            end
            last_hit = 1'b0;
            last_way = int'(resp_way);
        end
    endtask

    task automatic do_inval();
        @(negedge clk);
        inval = 1'b1;
        #1;
        chk(!req_ready, "R9", "ready low during invalidate", req_ready, 0);
        @(negedge clk);
        inval = 1'b0;
        m_clear();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R3 watchdog expired: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int tg, st, lat;
        bit h, nc;
        void'($urandom(32'd1234));
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !resp_valid && !fill_req, "R1", "reset state",
            {req_ready, resp_valid, fill_req}, 4);

        // R1: empty set fills ways in order
        for (int i = 0; i < 4; i++) begin
            do_access(mk_addr(5, i + 1, i * 3), 1'b0, 1'b0, i);
            chk(!last_hit && last_way == i, "R1", "invalid way first", last_way, i);
        end
        for (int i = 0; i < 4; i++) begin
            do_access(mk_addr(5, i + 1, 15), 1'b0, 1'b0, 0);
            chk(last_hit && last_way == i, "R4", "installed line hits", last_way, i);
        end
        // R5: full set after in-order touches evicts way 0
        do_access(mk_addr(5, 9, 0), 1'b0, 1'b0, 1);
        chk(last_way == 0, "R5", "tree victim", last_way, 0);

        // R6: hinted hit makes way 2 next victim
        for (int i = 0; i < 4; i++) do_access(mk_addr(7, i + 1, 0), 1'b0, 1'b0, 0);
        do_access(mk_addr(7, 3, 4), 1'b1, 1'b0, 0);
        do_access(mk_addr(7, 20, 0), 1'b0, 1'b0, 2);
        chk(last_way == 2, "R6", "hinted way evicted next", last_way, 2);

        // R7: hinted misses keep using one way
        for (int i = 0; i < 3; i++) begin
            do_access(mk_addr(7, 30 + i, 0), 1'b1, 1'b0, i);
            chk(last_way == 0, "R7", "hinted refill way", last_way, 0);
        end
        do_access(mk_addr(7, 2, 0), 1'b0, 1'b1, 0);
        chk(last_hit && last_way == 1, "R7", "other way resident", last_way, 1);
        do_access(mk_addr(7, 20, 0), 1'b0, 1'b1, 0);
        chk(last_hit && last_way == 2, "R7", "other way resident", last_way, 2);
        do_access(mk_addr(7, 4, 0), 1'b0, 1'b1, 0);
        chk(last_hit && last_way == 3, "R7", "other way resident", last_way, 3);

        // R8: uncached hits above did not move the tree; victim still way 0
        do_access(mk_addr(7, 40, 0), 1'b0, 1'b0, 0);
        chk(!last_hit && last_way == 0, "R8", "uncached hit left tree", last_way, 0);
        // R8: uncached miss allocates nothing
        do_access(mk_addr(9, 50, 0), 1'b0, 1'b1, 1);
        do_access(mk_addr(9, 50, 0), 1'b0, 1'b0, 0);
        chk(!last_hit && last_way == 0, "R8", "no allocation", last_hit, 0);

        // R9: invalidate-all at run time
        do_inval();
        do_access(mk_addr(7, 2, 0), 1'b0, 1'b0, 0);
        chk(!last_hit && last_way == 0, "R9", "miss after invalidate", last_hit, 0);

        // random traffic on two sets
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(99) < 2) do_inval();
            st  = ($urandom_range(1) == 0) ? 3 : 12;
            tg  = int'($urandom_range(6, 1));
            h   = ($urandom_range(99) < 25);
            nc  = ($urandom_range(99) < 15);
            lat = int'($urandom_range(3));
            do_access(mk_addr(st, tg, int'($urandom_range(15))), h, nc, lat);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule